// File: doc/BRIEF.md
# Configurable Sum-of-Products I/O Cell

This block is one input/output cell of a programmable sum-of-products logic device. It takes the OR-term result from the array and the value seen on its own pin. It returns a pin drive value, a pin enable and feedback signals for the array. A static configuration vector selects the mode. The output can be combinatorial or taken from a storage element. The storage element can be an edge-triggered register or a level-sensitive latch, and it can capture either the array result or the pin. The configuration also sets the output polarity, the clock or enable source and its polarity, the output-enable mode and the feedback source.

The cell runs on one reference clock, `clk`. The selected clock/enable source, either the common pin or the cell's own product term, is sampled on that clock. A register captures on the cycle in which the effective source is 1 and was 0 one cycle earlier. A latch captures on every cycle in which the effective source is 1. Preset and reset product terms and the block reset all take effect at the next reference edge.

A configuration bit reads 1 when it is erased and 0 when it is programmed. Vector layout, from bit 0 upward:

| Bits | Field | Meaning |
|------|-------|---------|
| 0 | `out_comb` | 1 = combinatorial, 0 = stored |
| 1 | `pol_low` | 1 = active-LOW (inverted), 0 = active-HIGH |
| 2 | `stor_reg` | 1 = register, 0 = latch |
| 3 | `dir_out` | 1 = capture the OR term, 0 = capture the pin |
| 4 | `ck_true` | 1 = true clock polarity, 0 = inverted |
| 5 | `ck_pin` | 1 = common clock pin, 0 = the cell's product term |
| 7:6 | `oe_mode` | enable mode, see R6 |
| 8 | `fb_sel` | single-feedback variant only: 1 = stored value, 0 = pin |

Top module: `pal_io_cell`

## Requirements
- R1: When `cfg_bits[0]`=1 (combinatorial), `pin_drive` equals `sum_in` XOR `cfg_bits[1]` in the same cycle. In the dual-feedback variant, `fb_state` carries that same value.
- R2: When `cfg_bits[0]`=0 and `cfg_bits[2]`=1 (register), the stored bit is loaded at the reference edge where the effective clock is 1 and was 0 at the previous edge. It holds at every other edge. `pin_drive` equals the stored bit XOR `cfg_bits[1]`.
- R3: When `cfg_bits[2]`=0 (latch), the stored bit takes the capture input at every reference edge where the effective enable is 1, so it follows that input one cycle later. It holds while the effective enable is 0.
- R4: The capture input is `sum_in` when `cfg_bits[3]`=1 and `pin_in` when `cfg_bits[3]`=0.
- R5: The effective clock/enable source is `ck_pin` when `cfg_bits[5]`=1 and `ck_pt` when it is 0. It is used as is when `cfg_bits[4]`=1 and inverted when `cfg_bits[4]`=0.
- R6: `pin_oe` follows `cfg_bits[7:6]`: 2'b11 follows `oe_pin`, 2'b10 follows `oe_pt`, 2'b01 is always 1, and 2'b00 is always 0.
- R7: A high `reset_pt` clears the stored bit at the next reference edge. This overrides `preset_pt` and any capture. A high `preset_pt` alone sets the stored bit to 1 and overrides capture.
- R8: A high `rst` clears the stored bit at the next reference edge. This overrides every other input.
- R9: With `DUAL_FB`=1, `fb_pin` equals `pin_in` and `fb_state` equals the stored bit, without polarity applied. With `DUAL_FB`=0, `fb_pin` is 0 and `fb_state` carries the stored bit when `cfg_bits[8]`=1, or `pin_in` when it is 0.
- R10: An all-ones configuration gives an active-LOW combinatorial output with the enable following `oe_pin`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset of the stored bit |
| cfg_bits | input | 9 | Static configuration vector |
| sum_in | input | 1 | OR-term result from the array |
| pin_in | input | 1 | Value seen on the cell's pin |
| ck_pin | input | 1 | Common clock/enable pin |
| ck_pt | input | 1 | The cell's own clock/enable product term |
| oe_pin | input | 1 | Common output-enable pin |
| oe_pt | input | 1 | Output-enable product term |
| preset_pt | input | 1 | Preset product term |
| reset_pt | input | 1 | Reset product term |
| pin_drive | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb_pin | output | 1 | Pin feedback (0 in the single-feedback variant) |
| fb_state | output | 1 | Stored-value or selected feedback |

## Verification
The stimulus re-draws the configuration every few dozen cycles while the data, clock-source and enable inputs change at random. This separates register capture from latch capture and pin capture from array capture across all four clock choices. Directed sequences cover three cases: a clock that is already high and stays high, which a register must ignore and a transparent latch must follow; preset and reset asserted together; and the all-ones erased vector. A second instance in single-feedback mode receives the same stimulus, so the feedback selection is compared directly against the dual variant.

// File: rtl/pal_cell_pkg.sv
package pal_cell_pkg;

    localparam int CFG_W = 9;

    typedef enum logic [1:0] {
        OE_OFF  = 2'b00,
        OE_ON   = 2'b01,
        OE_TERM = 2'b10,
        OE_PIN  = 2'b11
    } oe_mode_e;

    // packed MSB first; bit 0 is out_comb
    typedef struct packed {
        logic     fb_sel;
        oe_mode_e oe_mode;
        logic     ck_pin;
        logic     ck_true;
        logic     dir_out;
        logic     stor_reg;
        logic     pol_low;
        logic     out_comb;
    } cell_cfg_t;

    typedef struct packed {
        logic pin_in;
        logic st_val;
    } fb_src_t;

    function automatic logic pick_clock(input logic src_pin, input logic true_pol,
                                        input logic pin_v, input logic term_v);
        logic raw;
        raw = src_pin ? pin_v : term_v;
        return true_pol ? raw : ~raw;
    endfunction

endpackage

// File: rtl/pal_clk_sel.sv
module pal_clk_sel
    import pal_cell_pkg::*;
(
    input  logic src_pin,
    input  logic true_pol,
    input  logic ck_pin,
    input  logic ck_pt,
    output logic ck_eff
);

    always_comb begin
        ck_eff = pick_clock(src_pin, true_pol, ck_pin, ck_pt);
    end

endmodule

// File: rtl/pal_store.sv
module pal_store (
    input  logic clk,
    input  logic rst,
    input  logic is_reg,
    input  logic ck_eff,
    input  logic d,
    input  logic preset_pt,
    input  logic reset_pt,
    output logic q
);

    logic ck_prev;
    logic cap;

    always_comb begin
        cap = is_reg ? (ck_eff & ~ck_prev) : ck_eff;
    end

    always_ff @(posedge clk) begin
        ck_prev <= ck_eff;
    end

    always_ff @(posedge clk) begin
        if (rst)            q <= 1'b0;
        else if (reset_pt)  q <= 1'b0;
        else if (preset_pt) q <= 1'b1;
        else if (cap)       q <= d;
    end

    // R8
    rst_clear_chk: assert property (@(posedge clk) rst |=> !q);

    // R7
    reset_pt_chk: assert property (@(posedge clk) disable iff (rst)
        reset_pt |=> !q);

    // R7
    preset_pt_chk: assert property (@(posedge clk) disable iff (rst)
        (preset_pt && !reset_pt) |=> q);

    // R2
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (is_reg && !(ck_eff && !ck_prev) && !preset_pt && !reset_pt) |=> $stable(q));

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!is_reg && !ck_eff && !preset_pt && !reset_pt) |=> $stable(q));

endmodule

// File: rtl/pal_out_ctl.sv
module pal_out_ctl
    import pal_cell_pkg::*;
#(
    parameter bit DUAL_FB = 1'b1
) (
    input  cell_cfg_t cfg,
    input  logic      sum_in,
    input  logic      q,
    input  logic      pin_in,
    input  logic      oe_pin,
    input  logic      oe_pt,
    output logic      pin_drive,
    output logic      pin_oe,
    output logic      fb_pin,
    output logic      fb_state
);

    localparam bit SINGLE = !DUAL_FB;

    logic    comb_v;
    fb_src_t src;

    always_comb begin
        comb_v     = sum_in ^ cfg.pol_low;
        pin_drive  = cfg.out_comb ? comb_v : (q ^ cfg.pol_low);
        src.pin_in = pin_in;
        src.st_val = cfg.out_comb ? comb_v : q;
        unique case (cfg.oe_mode)
            OE_OFF:  pin_oe = 1'b0;
            OE_ON:   pin_oe = 1'b1;
            OE_TERM: pin_oe = oe_pt;
            default: pin_oe = oe_pin;
        endcase
    end

    generate
        if (DUAL_FB) begin : g_dual
            always_comb begin
                fb_pin   = src.pin_in;
                fb_state = (SINGLE && !cfg.fb_sel) ? src.pin_in : src.st_val;
            end
        end else begin : g_single
            always_comb begin
                fb_pin   = 1'b0;
                fb_state = cfg.fb_sel ? src.st_val : src.pin_in;
            end
        end
    endgenerate

endmodule

// File: rtl/pal_io_cell.sv
module pal_io_cell
    import pal_cell_pkg::*;
#(
    parameter bit DUAL_FB = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_bits,
    input  logic             sum_in,
    input  logic             pin_in,
    input  logic             ck_pin,
    input  logic             ck_pt,
    input  logic             oe_pin,
    input  logic             oe_pt,
    input  logic             preset_pt,
    input  logic             reset_pt,
    output logic             pin_drive,
    output logic             pin_oe,
    output logic             fb_pin,
    output logic             fb_state
);

    cell_cfg_t cfg;
    logic      ck_eff;
    logic      d_cap;
    logic      q;

    always_comb begin
        cfg   = cell_cfg_t'(cfg_bits);
        d_cap = cfg.dir_out ? sum_in : pin_in;
    end

    pal_clk_sel u_clk_sel (
        .src_pin  (cfg.ck_pin),
        .true_pol (cfg.ck_true),
        .ck_pin   (ck_pin),
        .ck_pt    (ck_pt),
        .ck_eff   (ck_eff)
    );

    pal_store u_store (
        .clk       (clk),
        .rst       (rst),
        .is_reg    (cfg.stor_reg),
        .ck_eff    (ck_eff),
        .d         (d_cap),
        .preset_pt (preset_pt),
        .reset_pt  (reset_pt),
        .q         (q)
    );

    pal_out_ctl #(.DUAL_FB(DUAL_FB)) u_out (
        .cfg       (cfg),
        .sum_in    (sum_in),
        .q         (q),
        .pin_in    (pin_in),
        .oe_pin    (oe_pin),
        .oe_pt     (oe_pt),
        .pin_drive (pin_drive),
        .pin_oe    (pin_oe),
        .fb_pin    (fb_pin),
        .fb_state  (fb_state)
    );

    generate
        if (DUAL_FB) begin : g_fb_chk
            // R1
            comb_fb_chk: assert property (@(posedge clk) disable iff (rst)
                cfg.out_comb |-> (fb_state == pin_drive));
        end
    endgenerate

endmodule

// File: tb/test_pal_io_cell.sv
`timescale 1ns/1ps
module test_pal_io_cell;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] cfg = 9'h0;
    logic       sum = 0, pin = 0, ckp = 0, ckt = 0, oep = 0, oet = 0, pre = 0, rs = 0;
    logic       drv, oe, fbp, fbs;
    logic       drv1, oe1, fbp1, fbs1;

    int n_chk = 0;
    int n_bad = 0;
    logic m_q = 1'b0;
    logic m_prev = 1'b0;

    always #4 clk = ~clk;

    pal_io_cell #(.DUAL_FB(1'b1)) i_pal_io_cell (
        .clk(clk), .rst(rst), .cfg_bits(cfg), .sum_in(sum), .pin_in(pin),
        .ck_pin(ckp), .ck_pt(ckt), .oe_pin(oep), .oe_pt(oet),
        .preset_pt(pre), .reset_pt(rs),
        .pin_drive(drv), .pin_oe(oe), .fb_pin(fbp), .fb_state(fbs));

    pal_io_cell #(.DUAL_FB(1'b0)) i_pal_io_cell_sf (
        .clk(clk), .rst(rst), .cfg_bits(cfg), .sum_in(sum), .pin_in(pin),
        .ck_pin(ckp), .ck_pt(ckt), .oe_pin(oep), .oe_pt(oet),
        .preset_pt(pre), .reset_pt(rs),
        .pin_drive(drv1), .pin_oe(oe1), .fb_pin(fbp1), .fb_state(fbs1));

    function automatic logic eff_ck();   // R5
        logic raw;
        raw = cfg[5] ? ckp : ckt;
        return cfg[4] ? raw : ~raw;
    endfunction

    function automatic logic exp_oe();   // R6
        case (cfg[7:6])
            2'b00:   return 1'b0;
            2'b01:   return 1'b1;
            2'b10:   return oet;
            default: return oep;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // inputs are already set; check outputs, then advance the model one edge
    task automatic apply(input string tag);
        logic st, ed, sel, cap, dcap, nq;
        string td;
        #1;
        st = cfg[0] ? (sum ^ cfg[1]) : m_q;
        ed = cfg[0] ? (sum ^ cfg[1]) : (m_q ^ cfg[1]);
        td = (tag != "") ? tag : (cfg[0] ? "R1" : (cfg[2] ? "R2" : "R3"));
        chk(td, "pin_drive", drv, ed);
        chk((tag != "") ? tag : "R6", "pin_oe", oe, exp_oe());
        chk("R9", "fb_pin dual", fbp, pin);
        chk((tag != "") ? tag : "R9", "fb_state dual", fbs, st);
        chk("R9", "fb_pin single", fbp1, 1'b0);
        chk("R9", "fb_state single", fbs1, cfg[8] ? st : pin);
        chk("R6", "pin_oe single", oe1, oe);
        sel  = eff_ck();
        cap  = cfg[2] ? (sel & ~m_prev) : sel;
        dcap = cfg[3] ? sum : pin;     // R4
        if (rst)      nq = 1'b0;       // R8
        else if (rs)  nq = 1'b0;       // R7
        else if (pre) nq = 1'b1;
        else if (cap) nq = dcap;
        else          nq = m_q;
        @(posedge clk);
        m_q    = nq;
        m_prev = sel;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        r = $urandom(32'h5A17);
        // reset, stored active-HIGH register, always enabled
        cfg = {1'b1, 2'b01, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0};
        @(negedge clk);
        @(posedge clk);
        m_q = 1'b0;
        m_prev = eff_ck();
        @(negedge clk);
        sum = 1; ckp = 1;
        apply("R8");
        apply("R8");
        rst = 0;

        // R10: erased vector
        cfg = 9'h1FF; sum = 1; oep = 1; apply("R10");
        sum = 0; oep = 0; apply("R10");

        // R5: inverted product-term clock, register, capture OR term
        cfg = {1'b1, 2'b01, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0};
        ckt = 1; sum = 1; apply("R5");
        ckt = 0; apply("R5");
        sum = 0; apply("R5");
        ckt = 1; apply("R5");
        ckt = 0; apply("R5");
        apply("R5");

        // R2: a clock stuck high makes no edge
        cfg = {1'b1, 2'b01, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0};
        ckp = 1; sum = 1; apply("R2");
        sum = 0; apply("R2");
        apply("R2");

        // R4: capture from the pin
        cfg = {1'b1, 2'b01, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0};
        ckp = 0; pin = 1; sum = 0; apply("R4");
        ckp = 1; apply("R4");
        apply("R4");

        // R3: latch with a true common enable
        cfg = {1'b1, 2'b01, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0};
        ckp = 1; sum = 0; apply("R3");
        sum = 1; apply("R3");
        ckp = 0; sum = 0; apply("R3");
        apply("R3");

        // R7: preset and reset together, then preset alone
        cfg = {1'b1, 2'b01, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0};
        pre = 1; rs = 1; apply("R7");
        rs = 0; apply("R7");
        pre = 0; apply("R7");

        // random mix
        for (int i = 0; i < 1500; i++) begin
            if (i % 25 == 0) cfg = 9'($urandom);
            sum = 1'($urandom); pin = 1'($urandom);
            ckp = 1'($urandom); ckt = 1'($urandom);
            oep = 1'($urandom); oet = 1'($urandom);
            pre = ($urandom % 8) == 0;
            rs  = ($urandom % 8) == 0;
            rst = ($urandom % 200) == 0;
            apply("");
        end
        finish_run();
    end

endmodule